// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that moves words between a peripheral FIFO and memory by following a linked list of transfer descriptors kept in memory. Software writes the address of the first descriptor and then sets the enable bit. From then on the channel fetches each descriptor and loads its working registers from it. It moves the programmed number of beats in bursts, one burst for each peripheral request, and then follows the link pointer to the next descriptor. A zero link pointer ends the chain.

The channel owns a single-port memory bus, which it uses for both descriptor fetches and data beats. It talks to one peripheral through a request/acknowledge pair. A small word-indexed register port gives software the start controls, the read-to-clear status and a read-back of the loaded descriptor state. The control state is taken only from fetched descriptors. A descriptor with a zero count is passed over without any data access.

Top module: `lld_dma_channel`

## Requirements
- R1: Writing 1 to bit 0 of ENABLE (register index 1) while idle starts the chain at the DPTR address (index 0). Reading ENABLE bit 0 returns 1 while the channel runs and 0 after it ends, because the bit clears itself.
- R2: A descriptor fetch is five word reads at DPTR+0, +4, +8, +12 and +16, loaded in that order into source address, destination address, CTLA, CTLB and link. SADDR, DADDR, CTLA and CTLB can be read at indices 3, 4, 5 and 6.
- R3: CTLA bits [15:0] hold the beat count, bits [18:16] the chunk code (burst = 2^code beats), bits [25:24] the source width code and bits [29:28] the destination width code. A width code of 0, 1 or 2 means 1, 2 or 4 bytes, and that byte count is the address step.
- R4: A descriptor whose count is zero makes no data access and no acknowledge, and the channel goes on to its link.
- R5: A link of zero ends the chain after that descriptor and sets STATUS bit 0 (chain done). DPTR then reads 0.
- R6: A burst starts only while per_req is high. It is min(chunk, remaining) beats, each a source read followed by a destination write. per_ack is high for exactly the cycle in which the burst's last write is accepted.
- R7: CTLB bit 0 holds the source address fixed and CTLB bit 1 holds the destination address fixed. An address that is not held advances by its width step after every beat.
- R8: Reading STATUS (index 2) clears it. Bit 0 is chain done and bit 1 is error.
- R9: A start or link pointer whose low two bits are not zero stops the channel with STATUS bit 1 set, and no fetch is made from it.
- R10: An error response from memory during a fetch or a data beat stops the channel and sets STATUS bit 1.
- R11: Software may write CTLB while the channel is idle and read the value back. Each descriptor fetch overwrites it.
- R12: Writes to DPTR, CTLB and ENABLE while the channel is busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears STATUS when it is selected) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| per_req | input | 1 | Peripheral burst request |
| per_ack | output | 1 | Peripheral burst acknowledge |

## Verification
Some properties are checked on every cycle by the assertions. Fetches are always word aligned. A data beat never runs with a zero remaining count or a burst larger than the chunk. A held source address stays put across a beat. The busy flag only falls together with a done or error event. A STATUS read clears it unless a new event arrives in the same cycle. Other behaviour can only be shown by the bench's scenarios. These include the order of the loaded descriptor fields, the skipping of a zero-count link inside a chain, the number of acknowledges for partial bursts, and the stall while per_req is low. They also cover the final address values for mixed widths and the error paths for bad pointers and bus faults.

// File: rtl/lld_dma_pkg.sv
package lld_dma_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned DW         = 32;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned CHK_W      = 3;
  localparam int unsigned DESC_WORDS = 5;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned RIDX_W     = 3;

  // control word A field positions
  localparam int unsigned CA_CNT_LSB = 0;
  localparam int unsigned CA_CHK_LSB = 16;
  localparam int unsigned CA_SW_LSB  = 24;
  localparam int unsigned CA_DW_LSB  = 28;

  // control word B bits
  localparam int unsigned CB_SRC_HOLD = 0;
  localparam int unsigned CB_DST_HOLD = 1;

  // register indices
  localparam logic [RIDX_W-1:0] RI_DPTR = 3'd0;
  localparam logic [RIDX_W-1:0] RI_EN   = 3'd1;
  localparam logic [RIDX_W-1:0] RI_STAT = 3'd2;
  localparam logic [RIDX_W-1:0] RI_SA   = 3'd3;
  localparam logic [RIDX_W-1:0] RI_DA   = 3'd4;
  localparam logic [RIDX_W-1:0] RI_CTLA = 3'd5;
  localparam logic [RIDX_W-1:0] RI_CTLB = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECIDE, ST_WAITREQ, ST_RD, ST_WR, ST_LINK
  } eng_state_t;
endpackage

// File: rtl/lld_dma_burst.sv
module lld_dma_burst #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CHK_W = 3
) (
  input  logic [CNT_W-1:0] remain,
  input  logic [CHK_W-1:0] chunk_code,
  output logic [CNT_W:0]   beats
);
  logic [CNT_W:0] chunk_beats;
  logic [CNT_W:0] remain_ext;

  always_comb begin
    chunk_beats = {{CNT_W{1'b0}}, 1'b1} << chunk_code;
    remain_ext  = {1'b0, remain};
    beats       = (remain_ext < chunk_beats) ? remain_ext : chunk_beats;
  end
endmodule

// File: rtl/lld_dma_regs.sv
module lld_dma_regs
  import lld_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done_p,
  input  logic              err_p,
  input  logic [AW-1:0]     ptr,
  input  logic [AW-1:0]     sa,
  input  logic [AW-1:0]     da,
  input  logic [DW-1:0]     ctla,
  input  logic [DW-1:0]     ctlb,
  output logic              start,
  output logic              sw_dptr_we,
  output logic              sw_ctlb_we
);
  logic [1:0] stat_q, stat_d;
  logic       stat_rc;

  always_comb begin
    start      = reg_wr && (reg_addr == RI_EN) && reg_wdata[0] && !busy;
    sw_dptr_we = reg_wr && (reg_addr == RI_DPTR) && !busy;
    sw_ctlb_we = reg_wr && (reg_addr == RI_CTLB) && !busy;
    stat_rc    = reg_rd && (reg_addr == RI_STAT);
    stat_d     = (stat_rc ? 2'b00 : stat_q) | {err_p, done_p};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 2'b00;
    else        stat_q <= stat_d;
  end

  always_comb begin
    case (reg_addr)
      RI_DPTR: reg_rdata = ptr;
      RI_EN:   reg_rdata = {{(DW-1){1'b0}}, busy};
      RI_STAT: reg_rdata = {{(DW-2){1'b0}}, stat_q};
      RI_SA:   reg_rdata = sa;
      RI_DA:   reg_rdata = da;
      RI_CTLA: reg_rdata = ctla;
      RI_CTLB: reg_rdata = ctlb;
      default: reg_rdata = '0;
    endcase
  end

  assert_status_rc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rc && !done_p && !err_p) |=> (stat_q == 2'b00));
  assert_start_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |-> !start);
endmodule

// File: rtl/lld_dma_engine.sv
module lld_dma_engine
  import lld_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sw_dptr_we,
  input  logic          sw_ctlb_we,
  input  logic [DW-1:0] sw_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  input  logic          per_req,
  output logic          per_ack,
  output logic          busy,
  output logic          done_p,
  output logic          err_p,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] sa,
  output logic [AW-1:0] da,
  output logic [DW-1:0] ctla,
  output logic [DW-1:0] ctlb
);
  eng_state_t       state_q, state_d;
  logic [AW-1:0]    ptr_q, ptr_d, sa_q, sa_d, da_q, da_d, nxt_q, nxt_d;
  logic [DW-1:0]    ctla_q, ctla_d, ctlb_q, ctlb_d, data_q, data_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W:0]   beat_q, beat_d, burst_beats;
  logic [CNT_W-1:0] cnt;
  logic [CHK_W-1:0] chk;
  logic [AW-1:0]    sstep, dstep;

  assign cnt   = ctla_q[CA_CNT_LSB +: CNT_W];
  assign chk   = ctla_q[CA_CHK_LSB +: CHK_W];
  assign sstep = {{(AW-1){1'b0}}, 1'b1} << ctla_q[CA_SW_LSB +: 2];
  assign dstep = {{(AW-1){1'b0}}, 1'b1} << ctla_q[CA_DW_LSB +: 2];

  lld_dma_burst #(.CNT_W(CNT_W), .CHK_W(CHK_W)) burst_i (
    .remain(remain_q), .chunk_code(chk), .beats(burst_beats)
  );

  always_comb begin
    state_d = state_q; ptr_d = ptr_q; sa_d = sa_q; da_d = da_q; nxt_d = nxt_q;
    ctla_d = ctla_q; ctlb_d = ctlb_q; data_d = data_q; idx_d = idx_q;
    remain_d = remain_q; beat_d = beat_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = data_q;
    per_ack = 1'b0; done_p = 1'b0; err_p = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (sw_dptr_we) ptr_d = sw_wdata;
        if (sw_ctlb_we) ctlb_d = sw_wdata;
        if (start) begin
          if (ptr_q[1:0] != 2'b00) err_p = 1'b1;
          else begin state_d = ST_FETCH; idx_d = '0; end
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
        if (mem_ack) begin
          if (mem_err) begin err_p = 1'b1; state_d = ST_IDLE; end
          else begin
            case (idx_q)
              3'd0:    sa_d   = mem_rdata;
              3'd1:    da_d   = mem_rdata;
              3'd2:    ctla_d = mem_rdata;
              3'd3:    ctlb_d = mem_rdata;
              default: nxt_d  = mem_rdata;
            endcase
            if (idx_q == IDX_W'(DESC_WORDS-1)) state_d = ST_DECIDE;
            else idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DECIDE: begin
        remain_d = cnt;
        state_d  = (cnt == '0) ? ST_LINK : ST_WAITREQ;
      end
      ST_WAITREQ: begin
        if (per_req) begin beat_d = burst_beats; state_d = ST_RD; end
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = sa_q;
        if (mem_ack) begin
          if (mem_err) begin err_p = 1'b1; state_d = ST_IDLE; end
          else begin data_d = mem_rdata; state_d = ST_WR; end
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = da_q;
        if (mem_ack) begin
          if (mem_err) begin err_p = 1'b1; state_d = ST_IDLE; end
          else begin
            if (!ctlb_q[CB_SRC_HOLD]) sa_d = sa_q + sstep;
            if (!ctlb_q[CB_DST_HOLD]) da_d = da_q + dstep;
            remain_d = remain_q - 1'b1;
            beat_d   = beat_q - 1'b1;
            per_ack  = (beat_q == {{CNT_W{1'b0}}, 1'b1});
            if (remain_q == {{(CNT_W-1){1'b0}}, 1'b1}) state_d = ST_LINK;
            else if (beat_q == {{CNT_W{1'b0}}, 1'b1}) state_d = ST_WAITREQ;
            else state_d = ST_RD;
          end
        end
      end
      ST_LINK: begin
        ptr_d = nxt_q;
        if (nxt_q == '0) begin done_p = 1'b1; state_d = ST_IDLE; end
        else if (nxt_q[1:0] != 2'b00) begin err_p = 1'b1; state_d = ST_IDLE; end
        else begin state_d = ST_FETCH; idx_d = '0; end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ptr_q <= '0; sa_q <= '0; da_q <= '0; nxt_q <= '0;
      ctla_q <= '0; ctlb_q <= '0; data_q <= '0; idx_q <= '0;
      remain_q <= '0; beat_q <= '0;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; sa_q <= sa_d; da_q <= da_d; nxt_q <= nxt_d;
      ctla_q <= ctla_d; ctlb_q <= ctlb_d; data_q <= data_d; idx_q <= idx_d;
      remain_q <= remain_d; beat_q <= beat_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign ptr  = ptr_q;
  assign sa   = sa_q;
  assign da   = da_q;
  assign ctla = ctla_q;
  assign ctlb = ctlb_q;

  assert_fetch_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |-> (mem_addr[1:0] == 2'b00));
  assert_no_zero_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD || state_q == ST_WR) |-> (remain_q != '0));
  assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |-> (beat_q != '0 && beat_q <= ({{CNT_W{1'b0}}, 1'b1} << chk)));
  assert_ack_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (mem_we && mem_ack));
  assert_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && mem_ack && !mem_err && ctlb_q[CB_SRC_HOLD]) |=> $stable(sa_q));
  assert_end_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_p || err_p));
endmodule

// File: rtl/lld_dma_channel.sv
module lld_dma_channel
  import lld_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              per_req,
  output logic              per_ack
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_i;
  logic          start, sw_dptr_we, sw_ctlb_we, busy, done_p, err_p;
  logic [AW-1:0] ptr, sa, da;
  logic [DW-1:0] ctla, ctlb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  lld_dma_regs regs_i (
    .clk(clk), .rst_n(rst_n_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done_p(done_p), .err_p(err_p), .ptr(ptr), .sa(sa), .da(da),
    .ctla(ctla), .ctlb(ctlb), .start(start), .sw_dptr_we(sw_dptr_we),
    .sw_ctlb_we(sw_ctlb_we)
  );

  lld_dma_engine eng_i (
    .clk(clk), .rst_n(rst_n_i), .start(start), .sw_dptr_we(sw_dptr_we),
    .sw_ctlb_we(sw_ctlb_we), .sw_wdata(reg_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .busy(busy), .done_p(done_p),
    .err_p(err_p), .ptr(ptr), .sa(sa), .da(da), .ctla(ctla), .ctlb(ctlb)
  );
endmodule

// File: tb/lld_dma_channel_tb.sv
`timescale 1ns/1ps
module lld_dma_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        per_req = 1'b1;
  logic        per_ack;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, ack_cnt = 0;
  logic [31:0] mem [0:255];

  always #10 clk = ~clk;

  lld_dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .per_req(per_req), .per_ack(per_ack)
  );

  // one-wait-state memory, bytes 0x000..0x3FF valid, beyond that answers with error
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_err   <= |mem_addr[31:10];
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we && !(|mem_addr[31:10])) mem[mem_addr[9:2]] <= mem_wdata;
      if (mem_we) wr_cnt++; else rd_cnt++;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
    if (per_ack) ack_cnt++;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctla(int cnt, int chk, int sw, int dw);
    return (32'(dw) << 28) | (32'(sw) << 24) | (32'(chk) << 16) | 32'(cnt);
  endfunction

  task automatic put_desc(int base, logic [31:0] s, logic [31:0] d,
                          logic [31:0] a, logic [31:0] b, logic [31:0] n);
    mem[base/4] = s; mem[base/4+1] = d; mem[base/4+2] = a;
    mem[base/4+3] = b; mem[base/4+4] = n;
  endtask

  task automatic prep_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 64 && i < 128) ? (32'hA500_0000 + 32'(i - 64)) : 32'h0;
    rd_cnt = 0; wr_cnt = 0; ack_cnt = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      reg_read(3'd1, v);
      if (v[0] == 1'b0) return;
    end
  endtask

  task automatic run(input logic [31:0] p);
    reg_write(3'd0, p);
    reg_write(3'd1, 32'h1);
    wait_idle();
  endtask

  // [15:0] count, [18:16] chunk code, [20] source hold, [31:24] expected acknowledges
  localparam logic [31:0] VEC [5] = '{
    32'h03_01_0005, 32'h02_02_0008, 32'h03_00_0003, 32'h01_13_0004, 32'h01_04_0010
  };

  logic [31:0] v, w;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    reg_read(3'd1, v); check("R1 reset busy", v, 32'h0);
    reg_read(3'd2, v); check("R8 reset status", v, 32'h0);
    reg_read(3'd0, v); check("R2 reset dptr", v, 32'h0);

    // table of single-descriptor transfers
    for (int t = 0; t < 5; t++) begin
      int cnt, hold, exp_acks;
      cnt = int'(VEC[t][15:0]); hold = int'(VEC[t][20]); exp_acks = int'(VEC[t][31:24]);
      prep_mem();
      put_desc(32'h40, 32'h100, 32'h200, mk_ctla(cnt, int'(VEC[t][18:16]), 2, 2), 32'(hold), 32'h0);
      run(32'h40);
      check("R6 acknowledge count", 32'(ack_cnt), 32'(exp_acks));
      check("R2 access count reads", 32'(rd_cnt), 32'(5 + cnt));
      for (int i = 0; i < cnt; i++)
        check("R7 destination word", mem[128 + i], 32'hA500_0000 + 32'(hold ? 0 : i));
      reg_read(3'd2, v); check("R5 done status", v, 32'h1);
    end

    // chain of three with a zero-count middle link; software CTLB is overwritten
    prep_mem();
    reg_write(3'd6, 32'h5A);
    reg_read(3'd6, v); check("R11 ctlb software write", v, 32'h5A);
    put_desc(32'h40, 32'h100, 32'h200, mk_ctla(2, 1, 2, 2), 32'h0, 32'h60);
    put_desc(32'h60, 32'h104, 32'h300, mk_ctla(0, 0, 2, 2), 32'h0, 32'h80);
    put_desc(32'h80, 32'h110, 32'h220, mk_ctla(2, 0, 2, 2), 32'h0, 32'h0);
    run(32'h40);
    check("R4 chain reads", 32'(rd_cnt), 32'd19);
    check("R4 chain writes", 32'(wr_cnt), 32'd4);
    check("R6 chain acknowledges", 32'(ack_cnt), 32'd3);
    check("R2 chain data a", mem[129], 32'hA500_0001);
    check("R2 chain data c", mem[137], 32'hA500_0005);
    check("R4 zero link untouched", mem[192], 32'h0);
    reg_read(3'd3, v); check("R2 saddr readback", v, 32'h118);
    reg_read(3'd4, v); check("R2 daddr readback", v, 32'h228);
    reg_read(3'd5, v); check("R2 ctla readback", v, mk_ctla(2, 0, 2, 2));
    reg_read(3'd6, v); check("R11 ctlb overwritten", v, 32'h0);
    reg_read(3'd0, v); check("R5 dptr end", v, 32'h0);
    reg_read(3'd1, v); check("R1 busy cleared", v, 32'h0);
    reg_read(3'd2, v); check("R8 status first read", v, 32'h1);
    reg_read(3'd2, v); check("R8 status cleared", v, 32'h0);

    // zero-count only descriptor
    prep_mem();
    put_desc(32'h40, 32'h100, 32'h200, mk_ctla(0, 2, 2, 2), 32'h0, 32'h0);
    run(32'h40);
    check("R4 zero count writes", 32'(wr_cnt), 32'd0);
    check("R4 zero count acks", 32'(ack_cnt), 32'd0);
    reg_read(3'd2, v); check("R4 zero count done", v, 32'h1);

    // width codes: source word, destination byte
    prep_mem();
    put_desc(32'h40, 32'h100, 32'h200, mk_ctla(3, 2, 2, 0), 32'h0, 32'h0);
    run(32'h40);
    reg_read(3'd3, v); check("R3 source step word", v, 32'h10C);
    reg_read(3'd4, v); check("R3 destination step byte", v, 32'h203);
    reg_read(3'd2, v);

    // destination held
    prep_mem();
    put_desc(32'h40, 32'h100, 32'h200, mk_ctla(3, 2, 2, 2), 32'h2, 32'h0);
    run(32'h40);
    reg_read(3'd4, v); check("R7 destination held", v, 32'h200);
    check("R7 held last word", mem[128], 32'hA500_0002);
    check("R7 held neighbour", mem[129], 32'h0);
    reg_read(3'd2, v);

    // request gating and writes ignored while busy
    prep_mem();
    per_req = 1'b0;
    put_desc(32'h40, 32'h100, 32'h200, mk_ctla(2, 1, 2, 2), 32'h0, 32'h0);
    reg_write(3'd0, 32'h40);
    reg_write(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    check("R6 stall writes", 32'(wr_cnt), 32'd0);
    check("R2 stall fetch reads", 32'(rd_cnt), 32'd5);
    reg_read(3'd1, v); check("R1 busy while running", v, 32'h1);
    reg_write(3'd0, 32'h300);
    reg_write(3'd6, 32'h3);
    reg_write(3'd1, 32'h1);
    per_req = 1'b1;
    wait_idle();
    check("R12 data after busy writes", mem[129], 32'hA500_0001);
    check("R12 single run reads", 32'(rd_cnt), 32'd7);
    reg_read(3'd0, v); check("R12 dptr kept", v, 32'h0);
    reg_read(3'd6, w); check("R12 ctlb kept", w, 32'h0);
    reg_read(3'd2, v); check("R12 status", v, 32'h1);

    // misaligned start pointer
    prep_mem();
    run(32'h42);
    check("R9 no fetch", 32'(rd_cnt), 32'd0);
    reg_read(3'd2, v); check("R9 start error", v, 32'h2);

    // misaligned link pointer
    prep_mem();
    put_desc(32'h40, 32'h100, 32'h200, mk_ctla(1, 0, 2, 2), 32'h0, 32'h62);
    run(32'h40);
    check("R9 link no fetch", 32'(rd_cnt), 32'd6);
    reg_read(3'd2, v); check("R9 link error", v, 32'h2);

    // bus error on data beat
    prep_mem();
    put_desc(32'h40, 32'h1000, 32'h200, mk_ctla(2, 1, 2, 2), 32'h0, 32'h0);
    run(32'h40);
    check("R10 beat error writes", 32'(wr_cnt), 32'd0);
    reg_read(3'd2, v); check("R10 beat error status", v, 32'h2);
    reg_read(3'd1, v); check("R10 stopped", v, 32'h0);

    // bus error during fetch
    prep_mem();
    run(32'h3F8);
    check("R10 fetch reads", 32'(rd_cnt), 32'd3);
    reg_read(3'd2, v); check("R10 fetch error status", v, 32'h2);

    finish_run();
  end
endmodule